// File: doc/BRIEF.md
# Command Ring Reader

This block drains a circular command queue that software keeps in system memory. Software fills 32-byte entries in the ring and then writes the write-offset register to publish them. When the unit is enabled and the new write offset differs from the read offset, the engine reads each pending entry as four 64-bit little-endian doublewords over a simple memory read port. It takes the opcode from the entry and either hands the entry to a downstream command handler through a valid/ready handshake or skips it. It then steps the read offset to the next entry, wrapping at the end of the ring.

The engine handles one entry at a time and stays busy until the read offset reaches the write offset. A failed memory read, or a fault reported by the handler, does not produce a bus error. It freezes the ring. The stalled flag is set and the read offset keeps pointing at the failing entry until software writes the write-offset register again with the retry bit set. The meaning of each command belongs to the downstream handler.

Top module: `cmdq_ring_reader`

## Requirements
- R1: After reset, `rdptr_q` is zero (offset 0, not stalled), and `busy`, `mem_req` and `cmd_valid` are low.
- R2: Draining starts only on a low-half write (`wptr_wr_lo`, alone or together with `wptr_wr_hi` for a full 64-bit write). The enable input must be high and the written offset must differ from the current read offset. Setting the enable input alone starts nothing.
- R3: A write to the high half only (`wptr_wr_hi` without `wptr_wr_lo`) never starts draining.
- R4: A written offset equal to or larger than `q_depth` is a programming error. No entry is read and the read offset is unchanged.
- R5: Entry n is read as four doublewords at `q_base + 32*n + 8*k`, for k = 0 to 3 in ascending order, and doubleword k lands in `cmd_entry[64k+63:64k]`. The address is held stable until `mem_rvalid`.
- R6: The opcode is `cmd_entry[7:0]`. Opcodes 0x05, 0x08 and 0x09 are presented with `cmd_valid`, which stays high with a stable payload until `cmd_ready`.
- R7: Any other opcode is consumed without raising `cmd_valid` and without setting the stalled flag.
- R8: After each successful entry the read offset becomes (offset + 1) modulo `q_depth`. `busy` stays high until the read offset equals the write offset.
- R9: When `mem_err` comes back with a read, or `cmd_fault` is high when `cmd_ready` is accepted, the stalled flag is set. The read offset stays on the failing entry and `busy` drops.
- R10: While stalled, a write-offset write with bit 0 (retry) clear has no effect. A write with retry set clears the stalled flag and resumes at the failing entry.
- R11: `rdptr_q` holds the read offset in bits [19:5] and the stalled flag in bit 0. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_enable | input | 1 | Unit enable |
| q_base | input | ADDR_W | Ring base byte address |
| q_depth | input | OFS_W+1 | Number of ring entries |
| wptr_wr_lo | input | 1 | Write strobe, low half of write-offset register |
| wptr_wr_hi | input | 1 | Write strobe, high half of write-offset register |
| wptr_wdata | input | 64 | Write data: offset in [19:5], retry in [0] |
| rdptr_q | output | 64 | Read-offset register: offset [19:5], stalled [0] |
| busy | output | 1 | Engine is draining the ring |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | DW_W | Memory read data |
| mem_err | input | 1 | Memory read failed (with mem_rvalid) |
| cmd_valid | output | 1 | Entry offered to handler |
| cmd_opcode | output | 8 | Opcode of offered entry |
| cmd_entry | output | DW_W*BEATS | Whole offered entry |
| cmd_ready | input | 1 | Handler accepts entry |
| cmd_fault | input | 1 | Handler failed the entry (with cmd_ready) |

## Verification
The assertions assume that `q_depth`, `q_base` and `q_enable` do not change while `busy` is high, that the write-offset register is not written during a drain, and that `mem_rvalid` is raised only while a request is outstanding. The bench keeps to these rules. It changes configuration and writes the offset register only after `busy` has fallen. Its memory model answers one beat at a time and only for a pending request. Its handler model raises `cmd_ready` for just one cycle per offered entry.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_STEP
  } cq_state_e;

  // register layout: offset field position and the flag bit
  localparam int OFS_LSB = 5;
  localparam int REG_W   = 64;

  localparam logic [7:0] OPC_BARRIER  = 8'h05;
  localparam logic [7:0] OPC_MAP_DEV  = 8'h08;
  localparam logic [7:0] OPC_MAP_COLL = 8'h09;

  function automatic logic op_has_action(input logic [7:0] op);
    return (op == OPC_BARRIER) || (op == OPC_MAP_DEV) || (op == OPC_MAP_COLL);
  endfunction

endpackage

// File: rtl/cmdq_ptr_regs.sv
module cmdq_ptr_regs #(
  parameter int OFS_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic             adv,
  input  logic [OFS_W-1:0] adv_ofs,
  input  logic             set_stall,
  input  logic             clr_stall,
  output logic [OFS_W-1:0] wr_ofs_q,
  output logic [OFS_W-1:0] rd_ofs_q,
  output logic             stalled_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ofs_q  <= '0;
      rd_ofs_q  <= '0;
      stalled_q <= 1'b0;
    end else begin
      if (wr_lo) wr_ofs_q <= wr_ofs;
      if (adv)   rd_ofs_q <= adv_ofs;
      if (set_stall)      stalled_q <= 1'b1;
      else if (clr_stall) stalled_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cmdq_beat_reader.sv
module cmdq_beat_reader #(
  parameter int ADDR_W = 52,
  parameter int OFS_W  = 15,
  parameter int DW_W   = 64,
  parameter int BEATS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [OFS_W-1:0]      go_idx,
  input  logic [ADDR_W-1:0]     base,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic                  mem_rvalid,
  input  logic [DW_W-1:0]       mem_rdata,
  input  logic                  mem_err,
  output logic [DW_W*BEATS-1:0] entry,
  output logic                  done,
  output logic                  fault
);

  localparam int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int BYTE_SH  = $clog2(DW_W / 8);
  localparam int ENT_SH   = $clog2(BEATS * DW_W / 8);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  function automatic logic [ADDR_W-1:0] beat_addr(
    input logic [ADDR_W-1:0] b,
    input logic [OFS_W-1:0]  idx,
    input logic [BEAT_W-1:0] beat
  );
    return b + (ADDR_W'(idx) << ENT_SH) + (ADDR_W'(beat) << BYTE_SH);
  endfunction

  logic              active_q;
  logic [BEAT_W-1:0] beat_q;
  logic [OFS_W-1:0]  idx_q;
  logic              done_q;
  logic              fault_q;
  logic [DW_W-1:0]   dw_q [BEATS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      for (int i = 0; i < BEATS; i++) dw_q[i] <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (go) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        idx_q    <= go_idx;
      end else if (active_q && mem_rvalid) begin
        if (mem_err) begin
          active_q <= 1'b0;
          fault_q  <= 1'b1;
        end else begin
          dw_q[beat_q] <= mem_rdata;
          if (beat_q == LAST_BEAT) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_pack
    assign entry[g*DW_W +: DW_W] = dw_q[g];
  end

  assign mem_req  = active_q;
  assign mem_addr = beat_addr(base, idx_q, beat_q);
  assign done     = done_q;
  assign fault    = fault_q;

endmodule

// File: rtl/cmdq_ring_reader.sv
module cmdq_ring_reader
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int OFS_W  = 15,
  parameter int DW_W   = 64,
  parameter int BEATS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  q_enable,
  input  logic [ADDR_W-1:0]     q_base,
  input  logic [OFS_W:0]        q_depth,
  input  logic                  wptr_wr_lo,
  input  logic                  wptr_wr_hi,
  input  logic [63:0]           wptr_wdata,
  output logic [63:0]           rdptr_q,
  output logic                  busy,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic                  mem_rvalid,
  input  logic [DW_W-1:0]       mem_rdata,
  input  logic                  mem_err,
  output logic                  cmd_valid,
  output logic [7:0]            cmd_opcode,
  output logic [DW_W*BEATS-1:0] cmd_entry,
  input  logic                  cmd_ready,
  input  logic                  cmd_fault
);

  localparam int ENT_W = DW_W * BEATS;
  localparam int HI_Z  = REG_W - OFS_W - OFS_LSB;

  function automatic logic [OFS_W-1:0] ring_next(
    input logic [OFS_W-1:0] cur,
    input logic [OFS_W:0]   depth
  );
    logic [OFS_W:0] inc;
    inc = {1'b0, cur} + 1'b1;
    return (inc >= depth) ? '0 : inc[OFS_W-1:0];
  endfunction

  cq_state_e        state_q, state_d;
  logic [OFS_W-1:0] wr_ofs_in;
  logic             retry_in;
  logic [OFS_W-1:0] wr_ofs_q, rd_ofs, rd_next, go_idx;
  logic             rd_stalled;
  logic             start_ok, fetch_go, adv_evt, stall_evt;
  logic             fetch_done, fetch_fault;
  logic [ENT_W-1:0] entry;

  // reserved register bits and the high-half strobe carry no state
  logic unused_wbits;
  assign unused_wbits = ^{wptr_wdata[REG_W-1:OFS_LSB+OFS_W],
                          wptr_wdata[OFS_LSB-1:1], wptr_wr_hi};

  assign wr_ofs_in = wptr_wdata[OFS_LSB +: OFS_W];
  assign retry_in  = wptr_wdata[0];
  assign rd_next   = ring_next(rd_ofs, q_depth);

  assign start_ok = wptr_wr_lo && q_enable && (state_q == ST_IDLE)
                 && ({1'b0, wr_ofs_in} < q_depth)
                 && (wr_ofs_in != rd_ofs)
                 && (!rd_stalled || retry_in);

  always_comb begin
    state_d   = state_q;
    fetch_go  = 1'b0;
    go_idx    = rd_ofs;
    adv_evt   = 1'b0;
    stall_evt = 1'b0;
    cmd_valid = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d  = ST_FETCH;
          fetch_go = 1'b1;
        end
      end
      ST_FETCH: begin
        if (fetch_fault) begin
          stall_evt = 1'b1;
          state_d   = ST_IDLE;
        end else if (fetch_done) begin
          state_d = op_has_action(entry[7:0]) ? ST_ISSUE : ST_STEP;
        end
      end
      ST_ISSUE: begin
        cmd_valid = 1'b1;
        if (cmd_ready) begin
          if (cmd_fault) begin
            stall_evt = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            state_d = ST_STEP;
          end
        end
      end
      ST_STEP: begin
        adv_evt = 1'b1;
        if (rd_next == wr_ofs_q) begin
          state_d = ST_IDLE;
        end else begin
          state_d  = ST_FETCH;
          fetch_go = 1'b1;
          go_idx   = rd_next;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  cmdq_ptr_regs #(.OFS_W(OFS_W)) ptr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (wptr_wr_lo),
    .wr_ofs    (wr_ofs_in),
    .adv       (adv_evt),
    .adv_ofs   (rd_next),
    .set_stall (stall_evt),
    .clr_stall (start_ok),
    .wr_ofs_q  (wr_ofs_q),
    .rd_ofs_q  (rd_ofs),
    .stalled_q (rd_stalled)
  );

  cmdq_beat_reader #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DW_W(DW_W), .BEATS(BEATS)
  ) rd_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (fetch_go),
    .go_idx     (go_idx),
    .base       (q_base),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_err    (mem_err),
    .entry      (entry),
    .done       (fetch_done),
    .fault      (fetch_fault)
  );

  assign rdptr_q    = {{HI_Z{1'b0}}, rd_ofs, {(OFS_LSB-1){1'b0}}, rd_stalled};
  assign busy       = (state_q != ST_IDLE);
  assign cmd_entry  = entry;
  assign cmd_opcode = entry[7:0];

endmodule

// File: rtl/cmdq_ring_reader_chk.sv
module cmdq_ring_reader_chk #(
  parameter int ADDR_W = 52,
  parameter int OFS_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_opcode,
  input logic              wptr_wr_lo,
  input logic              wptr_wr_hi,
  input logic              rd_stalled,
  input logic [OFS_W-1:0]  rd_ofs,
  input logic [OFS_W:0]    q_depth,
  input logic              adv_evt,
  input logic              stall_evt
);

  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode));

  // R9
  stall_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> rd_stalled && !busy && $stable(rd_ofs));

  // R9
  stalled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stalled |-> !cmd_valid && !mem_req);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_evt |=> $stable(rd_ofs));

  // R8
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> {1'b0, rd_ofs} < q_depth);

  // R3
  hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_wr_hi && !wptr_wr_lo && !busy |=> !busy);

endmodule

bind cmdq_ring_reader cmdq_ring_reader_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_opcode (cmd_opcode),
  .wptr_wr_lo (wptr_wr_lo),
  .wptr_wr_hi (wptr_wr_hi),
  .rd_stalled (rd_stalled),
  .rd_ofs     (rd_ofs),
  .q_depth    (q_depth),
  .adv_evt    (adv_evt),
  .stall_evt  (stall_evt)
);

// File: tb/cmdq_ring_reader_tb_top.sv
module cmdq_ring_reader_tb_top;

  localparam int ADDR_W = 52;
  localparam int OFS_W  = 15;
  localparam logic [ADDR_W-1:0] BASE = 52'h4_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              q_enable = 1'b1;
  logic [OFS_W:0]    q_depth = 16'd8;
  logic              wptr_wr_lo = 1'b0;
  logic              wptr_wr_hi = 1'b0;
  logic [63:0]       wptr_wdata = '0;
  logic [63:0]       rdptr_q;
  logic              busy;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rvalid = 1'b0;
  logic [63:0]       mem_rdata = '0;
  logic              mem_err = 1'b0;
  logic              cmd_valid;
  logic [7:0]        cmd_opcode;
  logic [255:0]      cmd_entry;
  logic              cmd_ready = 1'b0;
  logic              cmd_fault = 1'b0;

  always #4 clk = ~clk;

  cmdq_ring_reader dut_i (
    .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .q_base(BASE), .q_depth(q_depth),
    .wptr_wr_lo(wptr_wr_lo), .wptr_wr_hi(wptr_wr_hi), .wptr_wdata(wptr_wdata),
    .rdptr_q(rdptr_q), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_entry(cmd_entry),
    .cmd_ready(cmd_ready), .cmd_fault(cmd_fault)
  );

  int nchk = 0;
  int nerr = 0;
  int n_cmds = 0;
  int entry_bad = 0;
  bit finished = 0;
  logic [ADDR_W-1:0] bad_addr = '1;
  int bad_ent = -1;

  function automatic logic [7:0] op_of(input int e);
    case (e % 4)
      0: return 8'h08;
      1: return 8'h03;
      2: return 8'h05;
      default: return 8'h2A;
    endcase
  endfunction

  function automatic logic [63:0] dw_of(input int e, input int k);
    return {16'hC0DE, 8'(e), 8'(k), 24'h123456, (k == 0) ? op_of(e) : 8'(k)};
  endfunction

  // memory model: one response per pending request
  always @(negedge clk) begin
    if (mem_req && !mem_rvalid) begin
      logic [ADDR_W-1:0] off;
      off = mem_addr - BASE;
      mem_rvalid = 1'b1;
      mem_rdata  = dw_of(int'(off[7:5]), int'(off[4:3]));
      mem_err    = (mem_addr == bad_addr);
    end else begin
      mem_rvalid = 1'b0;
      mem_err    = 1'b0;
    end
  end

  // handler model: accept after one cycle, check payload
  always @(negedge clk) begin
    if (cmd_valid && !cmd_ready) begin
      int e;
      e = int'(rdptr_q[19:5]);
      cmd_ready = 1'b1;
      cmd_fault = (e == bad_ent);
      n_cmds++;
      if (cmd_entry != {dw_of(e,3), dw_of(e,2), dw_of(e,1), dw_of(e,0)} ||
          cmd_opcode != op_of(e)) begin
        entry_bad++;
        $display("FAIL R5/R6 entry %0d act=%h exp_op=%h", e, cmd_entry, op_of(e));
      end
    end else begin
      cmd_ready = 1'b0;
      cmd_fault = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_val(input int ofs, input bit st);
    return (64'(ofs) << 5) | 64'(st);
  endfunction

  task automatic wr_ptr(input int ofs, input bit retry, input bit lo, input bit hi);
    @(negedge clk);
    wptr_wdata = {32'hA5A5_0000, 12'h0, 15'(ofs), 4'h0, retry};
    wptr_wr_lo = lo;
    wptr_wr_hi = hi;
    @(posedge clk);
    @(negedge clk);
    wptr_wr_lo = 1'b0;
    wptr_wr_hi = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (busy) check(1'b0, "watchdog busy", 64'(busy), 64'd0);
    repeat (2) @(negedge clk);
  endtask

  // {write offset, expected read offset, expected handler count}
  localparam logic [47:0] VEC [5] = '{
    {16'd5, 16'd5, 16'd3},
    {16'd7, 16'd7, 16'd1},
    {16'd2, 16'd2, 16'd1},
    {16'd2, 16'd2, 16'd0},
    {16'd3, 16'd3, 16'd1}
  };

  initial begin
    int snap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(rdptr_q == 64'd0 && !busy && !mem_req && !cmd_valid, "R1 reset",
          {rdptr_q[60:0], busy, mem_req, cmd_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8/R6/R7/R2 table walk, full 64-bit writes
    for (int i = 0; i < 5; i++) begin
      snap = n_cmds;
      wr_ptr(int'(VEC[i][47:32]), 1'b0, 1'b1, 1'b1);
      wait_idle();
      check(rdptr_q == rd_val(int'(VEC[i][31:16]), 1'b0), "R8 R11 rd offset",
            rdptr_q, rd_val(int'(VEC[i][31:16]), 1'b0));
      check(n_cmds - snap == int'(VEC[i][15:0]), "R6 R7 handled count",
            64'(n_cmds - snap), 64'(VEC[i][15:0]));
    end

    // R2 enable low: write ignored, enabling later starts nothing
    q_enable = 1'b0;
    wr_ptr(6, 1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check(rdptr_q == rd_val(3, 0) && !busy, "R2 disabled", rdptr_q, rd_val(3, 0));
    q_enable = 1'b1;
    repeat (6) @(negedge clk);
    check(rdptr_q == rd_val(3, 0) && !busy, "R2 enable alone", rdptr_q, rd_val(3, 0));

    // R3 high half alone
    wr_ptr(6, 1'b0, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    check(rdptr_q == rd_val(3, 0) && !busy, "R3 high half", rdptr_q, rd_val(3, 0));

    // R4 out-of-range offset (8 and 9 with depth 8)
    snap = n_cmds;
    wr_ptr(8, 1'b0, 1'b1, 1'b0);
    repeat (6) @(negedge clk);
    wr_ptr(9, 1'b0, 1'b1, 1'b0);
    repeat (6) @(negedge clk);
    check(rdptr_q == rd_val(3, 0) && n_cmds == snap, "R4 range", rdptr_q, rd_val(3, 0));

    // R9 memory fault on entry 4, beat 1
    bad_addr = BASE + 52'd4 * 32 + 52'd8;
    wr_ptr(6, 1'b0, 1'b1, 1'b0);
    wait_idle();
    check(rdptr_q == rd_val(4, 1), "R9 mem fault", rdptr_q, rd_val(4, 1));

    // R10 write without retry while stalled
    snap = n_cmds;
    wr_ptr(6, 1'b0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    check(rdptr_q == rd_val(4, 1) && n_cmds == snap && !busy, "R10 no retry",
          rdptr_q, rd_val(4, 1));

    // R10 retry resumes at entry 4
    bad_addr = '1;
    wr_ptr(6, 1'b1, 1'b1, 1'b0);
    wait_idle();
    check(rdptr_q == rd_val(6, 0), "R10 retry", rdptr_q, rd_val(6, 0));
    check(n_cmds - snap == 1, "R10 retry count", 64'(n_cmds - snap), 64'd1);

    // R9 handler fault on entry 6
    bad_ent = 6;
    snap = n_cmds;
    wr_ptr(7, 1'b0, 1'b1, 1'b0);
    wait_idle();
    check(rdptr_q == rd_val(6, 1), "R9 handler fault", rdptr_q, rd_val(6, 1));
    bad_ent = -1;
    wr_ptr(7, 1'b1, 1'b1, 1'b0);
    wait_idle();
    check(rdptr_q == rd_val(7, 0) && n_cmds - snap == 2, "R10 retry after handler",
          rdptr_q, rd_val(7, 0));

    // R5 payload of every offered entry
    check(entry_bad == 0, "R5 entry contents", 64'(entry_bad), 64'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule